// File: doc/BRIEF.md
# Narrow-Bus to Wide-Line SRAM Controller

This controller sits between a 32-bit system bus and an on-chip memory built from several wide single-port SRAM banks. Each bank line is `BANK_BITS` wide (64 or 128), so one line holds two or four bus words. The block collects bus writes into a line buffer and packs them, with their byte strobes, into a single masked line write. A read fetches a whole line once and keeps it in a line register, so later reads that fall in the same line are served without touching the array. The array sees at most one full-width read or write per cycle, and only in one bank at a time. Back-to-back requests therefore run at full rate.

Requests arrive on a valid/ready channel that carries the address, the write data and the byte strobes. Read data returns on a separate bus, so no bus is shared or tri-stated. While `req_valid` is high and `req_ready` is low, the requester must hold every request field stable. Each accepted read produces exactly one `rsp_valid` pulse, one cycle after acceptance. The response channel has no ready signal, so the consumer must take each response in the cycle it is offered.

Each bank has a gate enable that acts as its clock and power enable. A gate closes once its bank has been idle for `IDLE_LIMIT` cycles. A request to a closed bank costs one extra wake-up cycle.

Top module: `wide_sram_ctrl`

## Requirements
- R1: After reset, every bit of `gate_en` is low and `rsp_valid` is low.
- R2: A request to a bank whose `gate_en` bit is low sees `req_ready` low for exactly one cycle. In that cycle the gate opens, and the request is accepted on the next cycle.
- R3: The word address is laid out as {bank, line, beat}, with the beat in the least significant bits. An accepted read yields `rsp_valid` high one cycle later, carrying the 32-bit word at that address. In every other cycle `rsp_valid` is low.
- R4: `req_strb[i]` writes byte i (bits 8i+7..8i) of the word. Bytes whose strobe is clear keep their earlier contents.
- R5: Writes to the same line are merged in the buffer. A write to a different line pushes the buffered line to the array in the same cycle, without lowering `req_ready`, and both lines later read back correctly.
- R6: A read to a line with a buffered, unwritten update stalls for exactly one cycle while that update is written. It then returns the newest data.
- R7: Once every byte of a line has been written, the line goes to the array at once. A following read of that line is not stalled.
- R8: Reads that hit the line held in the line register return correct data and cause no array access.
- R9: Back-to-back reads to awake banks, across lines and banks, are accepted every cycle. At most one bank is accessed per cycle.
- R10: A bank's gate closes exactly `IDLE_LIMIT` cycles after its last access.
- R11: A bank holding a buffered write never closes its gate, however long it stays idle.
- R12: The array is accessed only in banks whose gate is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and array clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (8) | Word address {bank, line, beat} |
| req_wdata | input | 32 | Write data |
| req_strb | input | 4 | Byte strobes for write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| gate_en | output | NUM_BANKS (4) | Per-bank clock/power enable |

## Verification
On every cycle, the assertions check the following:
- at most one bank is accessed, and only a bank whose gate is open;
- a read is answered exactly one cycle after it is accepted;
- a wake request opens the gate by the next edge;
- a bank with a pending buffered write keeps its gate open;
- the write buffer never holds a complete line;
- a flush stall empties the buffer.

Only the directed scenarios can show that data comes back correctly. This covers merged byte strobes, newest-data-after-flush, eviction to a second line and line-register hits. The scenarios also measure the exact stall counts and the exact idle cycle on which a gate closes.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  localparam int BUS_W     = 32;
  localparam int BUS_BYTES = BUS_W / 8;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_READ,
    OP_FLUSH_BUF,
    OP_WRITE_MERGED
  } sram_op_e;
endpackage

// File: rtl/wsc_sram_bank.sv
module wsc_sram_bank #(
  parameter int LINE_BITS = 128,
  parameter int DEPTH     = 16,
  localparam int LANES    = LINE_BITS / 8,
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 en,
  input  logic                 we,
  input  logic [AW-1:0]        addr,
  input  logic [LINE_BITS-1:0] wdata,
  input  logic [LANES-1:0]     wmask,
  output logic [LINE_BITS-1:0] rdata
);
  logic [LINE_BITS-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        for (int i = 0; i < LANES; i++) begin
          if (wmask[i]) mem[addr][8*i +: 8] <= wdata[8*i +: 8];
        end
      end else begin
        rdata <= mem[addr];
      end
    end
  end
endmodule

// File: rtl/wsc_bank_gate.sv
module wsc_bank_gate #(
  parameter int IDLE_LIMIT = 8,
  localparam int CNT_W     = $clog2(IDLE_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wake,
  input  logic touch,
  input  logic hold,
  output logic gate_en
);
  logic [CNT_W-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_en  <= 1'b0;
      idle_cnt <= '0;
    end else if (wake) begin
      gate_en  <= 1'b1;
      idle_cnt <= '0;
    end else if (touch || hold) begin
      idle_cnt <= '0;
    end else if (gate_en) begin
      if (idle_cnt == CNT_W'(IDLE_LIMIT - 1)) begin
        gate_en  <= 1'b0;
        idle_cnt <= '0;
      end else begin
        idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end

  assert_reset_gated_R1: assert property (@(posedge clk) !rst_n |=> !gate_en);
  assert_wake_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> gate_en);
  assert_hold_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && gate_en) |=> gate_en);
endmodule

// File: rtl/wsc_write_buffer.sv
module wsc_write_buffer import wsc_pkg::*; #(
  parameter int LINE_BITS = 128,
  parameter int TAG_W     = 6,
  localparam int LANES    = LINE_BITS / 8,
  localparam int BEAT_W   = $clog2(LINE_BITS / BUS_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 clear,
  input  logic [TAG_W-1:0]     in_tag,
  input  logic [BEAT_W-1:0]    in_beat,
  input  logic [BUS_W-1:0]     in_data,
  input  logic [BUS_BYTES-1:0] in_strb,
  output logic                 valid,
  output logic [TAG_W-1:0]     tag,
  output logic [LINE_BITS-1:0] data,
  output logic [LANES-1:0]     mask,
  output logic [LINE_BITS-1:0] mg_data,
  output logic [LANES-1:0]     mg_mask,
  output logic                 mg_full
);
  logic same_line;

  always_comb begin
    same_line = valid && (tag == in_tag);
    mg_data   = same_line ? data : '0;
    mg_mask   = same_line ? mask : '0;
    for (int i = 0; i < BUS_BYTES; i++) begin
      if (in_strb[i]) begin
        mg_data[int'(in_beat)*BUS_W + 8*i +: 8] = in_data[8*i +: 8];
        mg_mask[int'(in_beat)*BUS_BYTES + i]    = 1'b1;
      end
    end
    mg_full = &mg_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      tag   <= '0;
      data  <= '0;
      mask  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      tag   <= in_tag;
      data  <= mg_data;
      mask  <= mg_mask;
    end else if (clear) begin
      valid <= 1'b0;
      mask  <= '0;
    end
  end

  assert_buffer_never_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> !(&mask));
endmodule

// File: rtl/wide_sram_ctrl.sv
module wide_sram_ctrl import wsc_pkg::*; #(
  parameter int BANK_BITS      = 128,
  parameter int NUM_BANKS      = 4,
  parameter int LINES_PER_BANK = 16,
  parameter int IDLE_LIMIT     = 8,
  localparam int BEATS  = BANK_BITS / BUS_W,
  localparam int BEAT_W = $clog2(BEATS),
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int LINE_W = $clog2(LINES_PER_BANK),
  localparam int TAG_W  = BANK_W + LINE_W,
  localparam int ADDR_W = TAG_W + BEAT_W,
  localparam int LANES  = BANK_BITS / 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [BUS_W-1:0]     req_wdata,
  input  logic [BUS_BYTES-1:0] req_strb,
  output logic                 rsp_valid,
  output logic [BUS_W-1:0]     rsp_rdata,
  output logic [NUM_BANKS-1:0] gate_en
);
  // Address split: {bank, line, beat}; the beat sits in the low bits.
  logic [TAG_W-1:0]  req_tag;
  logic [BANK_W-1:0] req_bank;
  logic [BEAT_W-1:0] req_beat;
  assign req_tag  = req_addr[ADDR_W-1:BEAT_W];
  assign req_bank = req_addr[ADDR_W-1:ADDR_W-BANK_W];
  assign req_beat = req_addr[BEAT_W-1:0];

  logic                 wb_valid, mg_full;
  logic [TAG_W-1:0]     wb_tag;
  logic [BANK_BITS-1:0] wb_data, mg_data;
  logic [LANES-1:0]     wb_mask, mg_mask;

  logic                 rl_valid;
  logic [TAG_W-1:0]     rl_tag;
  logic [BANK_BITS-1:0] rl_data;
  logic                 rl_hit;

  logic rd_flush_need, fire, wr_fire;
  sram_op_e op;
  logic [TAG_W-1:0]     op_tag;
  logic [BANK_W-1:0]    op_bank;
  logic                 mem_we;
  logic [BANK_BITS-1:0] mem_wdata;
  logic [LANES-1:0]     mem_wmask;
  logic [NUM_BANKS-1:0] bank_en;
  logic [BANK_BITS-1:0] bank_q [NUM_BANKS];

  assign rd_flush_need = req_valid && !req_write && wb_valid && (wb_tag == req_tag);
  assign req_ready     = gate_en[req_bank] && !rd_flush_need;
  assign fire          = req_valid && req_ready;
  assign wr_fire       = fire && req_write;
  assign rl_hit        = rl_valid && (rl_tag == req_tag);

  // One array operation per cycle at most: read miss, full-line write, or buffer flush.
  always_comb begin
    op     = OP_NONE;
    op_tag = req_tag;
    if (fire && !req_write && !rl_hit) begin
      op = OP_READ;
    end else if (wr_fire && mg_full) begin
      op = OP_WRITE_MERGED;
    end else if ((wr_fire && wb_valid && wb_tag != req_tag) || rd_flush_need) begin
      op     = OP_FLUSH_BUF;
      op_tag = wb_tag;
    end
  end

  assign op_bank   = op_tag[TAG_W-1:LINE_W];
  assign mem_we    = (op == OP_WRITE_MERGED) || (op == OP_FLUSH_BUF);
  assign mem_wdata = (op == OP_WRITE_MERGED) ? mg_data : wb_data;
  assign mem_wmask = (op == OP_WRITE_MERGED) ? mg_mask : wb_mask;

  wsc_write_buffer #(.LINE_BITS(BANK_BITS), .TAG_W(TAG_W)) i_wbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (wr_fire && !mg_full),
    .clear   (rd_flush_need || (wr_fire && mg_full)),
    .in_tag  (req_tag),
    .in_beat (req_beat),
    .in_data (req_wdata),
    .in_strb (req_strb),
    .valid   (wb_valid),
    .tag     (wb_tag),
    .data    (wb_data),
    .mask    (wb_mask),
    .mg_data (mg_data),
    .mg_mask (mg_mask),
    .mg_full (mg_full)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic wake, touch, hold;
    assign bank_en[b] = (op != OP_NONE) && (op_bank == BANK_W'(b));
    assign wake  = req_valid && (req_bank == BANK_W'(b)) && !gate_en[b];
    assign touch = (fire && req_bank == BANK_W'(b)) || bank_en[b];
    assign hold  = wb_valid && (wb_tag[TAG_W-1:LINE_W] == BANK_W'(b));

    wsc_bank_gate #(.IDLE_LIMIT(IDLE_LIMIT)) i_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .wake    (wake),
      .touch   (touch),
      .hold    (hold),
      .gate_en (gate_en[b])
    );

    wsc_sram_bank #(.LINE_BITS(BANK_BITS), .DEPTH(LINES_PER_BANK)) i_bank (
      .clk   (clk),
      .en    (bank_en[b]),
      .we    (mem_we),
      .addr  (op_tag[LINE_W-1:0]),
      .wdata (mem_wdata),
      .wmask (mem_wmask),
      .rdata (bank_q[b])
    );

    assert_access_awake_R12: assert property (@(posedge clk) disable iff (!rst_n)
      bank_en[b] |-> gate_en[b]);
  end

  // Response path and line register.
  logic                 rsp_sram_q;
  logic [BEAT_W-1:0]    rsp_beat_q;
  logic [BANK_W-1:0]    rsp_bank_q;
  logic [BANK_BITS-1:0] line_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_sram_q <= 1'b0;
      rsp_beat_q <= '0;
      rsp_bank_q <= '0;
      rl_valid   <= 1'b0;
      rl_tag     <= '0;
      rl_data    <= '0;
    end else begin
      rsp_valid  <= fire && !req_write;
      rsp_sram_q <= (op == OP_READ);
      if (fire) begin
        rsp_beat_q <= req_beat;
        rsp_bank_q <= req_bank;
      end
      if (op == OP_READ) begin
        rl_valid <= 1'b1;
        rl_tag   <= req_tag;
      end else if (wr_fire && rl_hit) begin
        rl_valid <= 1'b0;
      end
      if (rsp_sram_q) rl_data <= bank_q[rsp_bank_q];
    end
  end

  assign line_out  = rsp_sram_q ? bank_q[rsp_bank_q] : rl_data;
  assign rsp_rdata = line_out[int'(rsp_beat_q)*BUS_W +: BUS_W];

  assert_one_bank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_en));
  assert_rsp_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !req_write) |=> rsp_valid);
  assert_rsp_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && !req_write) |=> !rsp_valid);
  assert_hit_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !req_write && rl_hit) |-> (bank_en == '0));
  assert_flush_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && gate_en[req_bank] && !req_ready) |=> !wb_valid);
endmodule

// File: tb/test_wide_sram_ctrl.sv
module test_wide_sram_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int IDLE_LIMIT = 8;
  localparam int WORDS      = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_strb = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [3:0]  gate_en;

  wide_sram_ctrl #(.BANK_BITS(128), .NUM_BANKS(4), .LINES_PER_BANK(16),
                   .IDLE_LIMIT(IDLE_LIMIT)) i_wide_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_strb(req_strb), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .gate_en(gate_en));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [WORDS];
  logic [31:0] got_data;
  logic        got_valid;
  int          stalls;

  function automatic logic [7:0] mk_addr(int bank, int line, int beat);
    return 8'(bank*64 + line*4 + beat);
  endfunction

  function automatic logic [31:0] pat(int a, int salt);
    return 32'h5A00_0000 ^ 32'(a * 32'h0101_0103) ^ 32'(salt << 20);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Presents one request just after a negedge, waits for acceptance, returns at the
  // negedge after the accepting edge with the response sampled.
  task automatic access(input bit wr, input logic [7:0] a, input logic [31:0] d,
                        input logic [3:0] s);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_strb = s;
    stalls = 0;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1;
      stalls++;
    end
    check(gate_en[a[7:6]] === 1'b1, "R12 gate open at acceptance", 32'(gate_en), 32'hF);
    @(posedge clk);
    @(negedge clk);
    got_valid = rsp_valid;
    got_data  = rsp_rdata;
    req_valid = 1'b0; req_write = 1'b0;
    if (wr) begin
      for (int i = 0; i < 4; i++)
        if (s[i]) model[a][8*i +: 8] = d[8*i +: 8];
    end
  endtask

  task automatic read_check(input logic [7:0] a, input string req, input int exp_stalls);
    access(1'b0, a, '0, '0);
    check(got_valid === 1'b1, req, 32'(got_valid), 32'd1);
    check(got_data === model[a], req, got_data, model[a]);
    if (exp_stalls >= 0) check(stalls == exp_stalls, req, 32'(stalls), 32'(exp_stalls));
  endtask

  task automatic init_line(input int bank, input int line);
    for (int b = 0; b < 4; b++)
      access(1'b1, mk_addr(bank, line, b), pat(bank*64 + line*4 + b, 1), 4'hF);
  endtask

  task automatic t_reset();
    check(gate_en === 4'b0000, "R1 gates closed after reset", 32'(gate_en), 32'h0);
    check(rsp_valid === 1'b0, "R1 no response after reset", 32'(rsp_valid), 32'h0);
  endtask

  task automatic t_wake_full_line();
    access(1'b1, mk_addr(0, 0, 0), pat(0, 2), 4'hF);
    check(stalls == 1, "R2 one wake cycle", 32'(stalls), 32'd1);
    check(got_valid === 1'b0, "R3 no response to write", 32'(got_valid), 32'd0);
    for (int b = 1; b < 4; b++) begin
      access(1'b1, mk_addr(0, 0, b), pat(b, 2), 4'hF);
      check(stalls == 0, "R5 same-line write merges", 32'(stalls), 32'd0);
    end
    read_check(mk_addr(0, 0, 2), "R7 full line written, read not stalled", 0);
    read_check(mk_addr(0, 0, 0), "R8 line register hit beat0", 0);
    read_check(mk_addr(0, 0, 1), "R8 line register hit beat1", 0);
    read_check(mk_addr(0, 0, 3), "R3 addressed word returned", 0);
  endtask

  task automatic t_strobe_flush();
    access(1'b1, mk_addr(0, 0, 1), 32'hC3C3_3C3C, 4'b0101);
    check(stalls == 0, "R5 partial write buffered", 32'(stalls), 32'd0);
    read_check(mk_addr(0, 0, 1), "R6 flush before read, R4 strobes merged", 1);
    read_check(mk_addr(0, 0, 0), "R4 other word untouched", 0);
  endtask

  task automatic t_evict();
    init_line(0, 1);
    init_line(0, 2);
    access(1'b1, mk_addr(0, 1, 3), 32'h1111_2222, 4'b1100);
    access(1'b1, mk_addr(0, 2, 0), 32'h3333_4444, 4'b0011);
    check(stalls == 0, "R5 eviction without stall", 32'(stalls), 32'd0);
    read_check(mk_addr(0, 1, 3), "R5 evicted line reads back", 0);
    read_check(mk_addr(0, 2, 0), "R6 pending line flushed then read", 1);
  endtask

  task automatic t_stream();
    logic [7:0] a, prev;
    prev = '0;
    for (int l = 0; l < 4; l++) init_line(1, l);
    for (int l = 0; l < 4; l++) init_line(2, l);
    read_check(mk_addr(1, 0, 0), "R2 wake for streaming", 1);
    for (int i = 0; i < 8; i++) begin
      a = mk_addr((i % 2 == 0) ? 2 : 1, i / 2, i % 4);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      #1;
      if (i > 0) begin
        check(rsp_valid === 1'b1, "R9 streamed response valid", 32'(rsp_valid), 32'd1);
        check(rsp_rdata === model[prev], "R9 streamed data", rsp_rdata, model[prev]);
      end
      check(req_ready === 1'b1, "R9 accepted every cycle", 32'(req_ready), 32'd1);
      prev = a;
      @(posedge clk);
      @(negedge clk);
    end
    #1;
    check(rsp_valid === 1'b1, "R9 last streamed response", 32'(rsp_valid), 32'd1);
    check(rsp_rdata === model[prev], "R9 last streamed data", rsp_rdata, model[prev]);
    req_valid = 1'b0;
    repeat (IDLE_LIMIT - 1) @(negedge clk);
    #1;
    check(gate_en[1] === 1'b1, "R10 gate open before limit", 32'(gate_en), 32'h2);
    check(gate_en[2] === 1'b0, "R10 earlier bank gated at limit", 32'(gate_en), 32'h2);
    @(negedge clk); #1;
    check(gate_en[1] === 1'b0, "R10 gate closed at limit", 32'(gate_en), 32'h0);
  endtask

  task automatic t_hold();
    access(1'b1, mk_addr(3, 5, 2), 32'hDEAD_BEEF, 4'hF);
    check(stalls == 1, "R2 wake bank3", 32'(stalls), 32'd1);
    repeat (3*IDLE_LIMIT) @(negedge clk);
    #1;
    check(gate_en[3] === 1'b1, "R11 pending write keeps gate open", 32'(gate_en), 32'h8);
    read_check(mk_addr(3, 5, 2), "R6 flush after long idle", 1);
    repeat (IDLE_LIMIT) @(negedge clk);
    #1;
    check(gate_en[3] === 1'b0, "R10 gate closes after flush and idle", 32'(gate_en), 32'h0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    @(negedge clk);
    t_wake_full_line();
    t_strobe_flush();
    t_evict();
    t_stream();
    @(negedge clk);
    t_hold();
    summary();
  end
endmodule